// File: doc/BRIEF.md
# Tunable Phase-Accumulator Oscillator with Error Offset

This block is a numerically controlled oscillator built around a 32-bit phase accumulator. On every clock edge the accumulator adds a step. The step is the sum of a tuning word that software programs and a signed frequency-error value that a demodulator loop drives live, cycle by cycle. The output frequency is f_clk × step / 2^32. To avoid aliasing the step must stay below half the clock rate, and in normal use it stays below about 35 percent of it.

Software programs the tuning word one byte at a time through a small write port. The three lower bytes go into a holding stage. The word only moves into the accumulator path when the top byte is written, so the oscillator never runs on a half-updated word. The block outputs the upper 12 bits of the phase and a one-cycle pulse each time the accumulator wraps. A sine/cosine table and a loop filter would be attached outside the block.

The reset input clears the block asynchronously. Its release is synchronised inside the block over two clock edges.

Top module: `nco_offset_core`

## Requirements
- R1: Byte lanes of the tuning word: a write to address 0x03 sets bits 7..0, 0x04 sets bits 15..8, 0x05 sets bits 23..16 and 0x06 sets bits 31..24. Bit 0 of the data byte maps to the lowest bit of its lane.
- R2: Writes to 0x03, 0x04 and 0x05 are only held in a stage and do not change the step. A write to 0x06 commits all four bytes at once. The new word takes effect from the clock edge after the edge that captured that write.
- R3: The step is the active tuning word plus the 16-bit two's-complement `freq_err`, sign-extended to 32 bits, modulo 2^32. The error is applied on every edge with no delay and no holding.
- R4: On each rising edge the 32-bit accumulator takes accumulator + step, modulo 2^32. `phase_out` is the registered upper 12 bits of the accumulator.
- R5: `wrap_pulse` is high for the one cycle after an edge whose addition carried out of bit 31, and low after every other edge. For a step of 2^28 it pulses exactly once every 16 cycles.
- R6: Writes with `wr_en` low, and writes to any address outside 0x03..0x06, change neither the stage nor the active word.
- R7: While reset is asserted, the accumulator, the stage, the active word and `wrap_pulse` are all zero, so `phase_out` reads 0 and `wrap_pulse` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data byte |
| freq_err | input | 16 | Signed frequency error from the demodulator loop |
| phase_out | output | 12 | Upper bits of the phase accumulator |
| wrap_pulse | output | 1 | One-cycle pulse after an accumulator wrap |

## Verification
The oscillator is run with tuning words spread across the whole 32-bit range and combined with positive, negative, zero and extreme error values. This shows whether the sign extension and the modulo-2^32 sum are handled correctly. A per-cycle error sequence tests that the error offset is live and not sampled and held. Partial byte writes, writes to neighbouring addresses and writes with the strobe low each hold the step at zero, which separates staging from committing. A step of 2^28 must give an exact count of wrap pulses, which separates the carry pulse from a pulse derived from the phase level.

// File: rtl/nco_offset_pkg.sv
package nco_offset_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lanes_of(input int unsigned width);
    return width / BYTE_W;
  endfunction
endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nco_word_regs.sv
module nco_word_regs
  import nco_offset_pkg::*;
#(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [ACC_W-1:0]  word_o
);
  localparam int unsigned NUM_LANES = lanes_of(ACC_W);
  localparam int unsigned STAGE_W   = ACC_W - BYTE_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE_ADDR + NUM_LANES - 1);

  logic [STAGE_W-1:0] stage_flat;
  logic [ACC_W-1:0]   word_q;
  logic [ACC_W-1:0]   word_d;
  logic               commit_en;

  for (genvar gl = 0; gl < NUM_LANES - 1; gl++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + gl);
    logic              lane_en;
    logic [BYTE_W-1:0] lane_q;
    logic [BYTE_W-1:0] lane_d;

    assign lane_en = wr_en && (wr_addr == LANE_ADDR);

    always_comb begin
      lane_d = lane_q;
      if (lane_en) begin
        lane_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else begin
        lane_q <= lane_d;
      end
    end

    assign stage_flat[gl*BYTE_W +: BYTE_W] = lane_q;
  end

  assign commit_en = wr_en && (wr_addr == TOP_ADDR);

  always_comb begin
    word_d = word_q;
    if (commit_en) begin
      word_d = {wr_data, stage_flat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/nco_step_sum.sv
module nco_step_sum #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned ERR_W = 16
) (
  input  logic [ACC_W-1:0] word_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [ACC_W-1:0] step_o
);
  localparam int unsigned EXT_W = ACC_W - ERR_W;

  logic [ACC_W-1:0] err_ext;

  always_comb begin
    err_ext = {{EXT_W{err_i[ERR_W-1]}}, err_i};
    step_o  = word_i + err_ext;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   step_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             wrap_q;
  logic             wrap_d;

  always_comb begin
    {wrap_d, acc_d} = {1'b0, acc_q} + {1'b0, step_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      wrap_q <= wrap_d;
    end
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q[ACC_W-1 -: PHASE_W];
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/nco_offset_core.sv
module nco_offset_core #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned PHASE_W   = 12,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [ERR_W-1:0]   freq_err,
  output logic [PHASE_W-1:0] phase_out,
  output logic               wrap_pulse
);
  logic             rst_sync_n;
  logic [ACC_W-1:0] fcw_active;
  logic [ACC_W-1:0] step_word;
  logic [ACC_W-1:0] acc_full;

  nco_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nco_word_regs #(
    .ACC_W     (ACC_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .word_o  (fcw_active)
  );

  nco_step_sum #(
    .ACC_W (ACC_W),
    .ERR_W (ERR_W)
  ) u_sum (
    .word_i (fcw_active),
    .err_i  (freq_err),
    .step_o (step_word)
  );

  nco_phase_acc #(
    .ACC_W   (ACC_W),
    .PHASE_W (PHASE_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_i  (step_word),
    .acc_o   (acc_full),
    .phase_o (phase_out),
    .wrap_o  (wrap_pulse)
  );
endmodule

// File: rtl/nco_offset_core_chk.sv
module nco_offset_core_chk #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned PHASE_W   = 12,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 3
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [7:0]         wr_data,
  input logic [ERR_W-1:0]   freq_err,
  input logic [ACC_W-1:0]   word,
  input logic [ACC_W-1:0]   acc,
  input logic [PHASE_W-1:0] phase_out,
  input logic               wrap_pulse
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE_ADDR + ACC_W/8 - 1);

  logic [ACC_W-1:0] err_wide;
  logic             top_write;

  assign err_wide  = {{(ACC_W-ERR_W){freq_err[ERR_W-1]}}, freq_err};
  assign top_write = wr_en && (wr_addr == TOP_ADDR);

  // R2: the active word moves only after a write to the top byte
  a_r2_commit_on_top: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(rst_ns) && (word != $past(word))) |-> $past(top_write));

  // R1: the top byte lane takes the data of the committing write
  a_r1_top_lane: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(rst_ns) && $past(top_write)) |-> (word[ACC_W-1 -: 8] == $past(wr_data)));

  // R4: the accumulator advances by word plus sign-extended error
  a_r4_accumulate: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(rst_ns) |-> (acc == ACC_W'($past(acc) + $past(word) + $past(err_wide))));

  // R5: a wrap pulse comes with a phase that did not rise
  a_r5_wrap_drop: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(rst_ns) && wrap_pulse) |-> (phase_out <= $past(phase_out)));

  // R5: with no wrap the phase did not fall
  a_r5_no_wrap_rise: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(rst_ns) && !wrap_pulse) |-> (phase_out >= $past(phase_out)));
endmodule

bind nco_offset_core nco_offset_core_chk #(
  .ACC_W     (ACC_W),
  .ERR_W     (ERR_W),
  .PHASE_W   (PHASE_W),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .freq_err   (freq_err),
  .word       (fcw_active),
  .acc        (acc_full),
  .phase_out  (phase_out),
  .wrap_pulse (wrap_pulse)
);

// File: tb/tb_nco_offset_core.sv
module tb_nco_offset_core;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] freq_err;
  logic [11:0] phase_out;
  logic        wrap_pulse;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic        model_run = 0;
  logic [31:0] m_acc  = '0;
  logic [31:0] m_word = '0;
  logic [23:0] m_st   = '0;
  logic        m_wrap = 0;

  nco_offset_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .freq_err   (freq_err),
    .phase_out  (phase_out),
    .wrap_pulse (wrap_pulse)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Arithmetic model: R1 lanes, R2 commit, R3 step sum, R4 accumulate, R5 carry
  always @(posedge clk) begin : mdl
    logic [32:0] s;
    if (model_run) begin
      s = {1'b0, m_acc} + {1'b0, m_word + {{16{freq_err[15]}}, freq_err}};
      m_acc  <= s[31:0];
      m_wrap <= s[32];
      if (wr_en) begin
        case (wr_addr)
          8'h03: m_st[7:0]   <= wr_data;
          8'h04: m_st[15:8]  <= wr_data;
          8'h05: m_st[23:16] <= wr_data;
          8'h06: m_word      <= {wr_data, m_st};
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_cycle(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, 32'(phase_out), 32'(m_acc[31:20]));
    chk(tag, 32'(wrap_pulse), 32'(m_wrap));
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d, input logic en, input string tag);
    wr_en = en; wr_addr = a; wr_data = d;
    step_cycle(tag);
    wr_en = 0; wr_addr = 8'h00; wr_data = 8'h00;
  endtask

  task automatic load_word(input logic [31:0] w, input string tag);
    wr_byte(8'h03, w[7:0],   1, tag);
    wr_byte(8'h04, w[15:8],  1, tag);
    wr_byte(8'h05, w[23:16], 1, tag);
    wr_byte(8'h06, w[31:24], 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] words [6];
    logic [15:0] errs  [4];
    int pulses;
    words = '{32'h0000_0001, 32'h1234_5678, 32'h5999_9999, 32'h8000_0000, 32'hFFFF_FF00, 32'h0100_0000};
    errs  = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFF38};

    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; freq_err = 0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared during reset
    chk("R7 reset phase", 32'(phase_out), 32'h0);
    chk("R7 reset wrap", 32'(wrap_pulse), 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R7 after release", 32'(phase_out), 32'h0);
    model_run = 1;

    // R2: staged lower bytes alone leave the step at zero
    wr_byte(8'h03, 8'hFF, 1, "R2");
    wr_byte(8'h04, 8'hFF, 1, "R2");
    wr_byte(8'h05, 8'hFF, 1, "R2");
    repeat (8) step_cycle("R2");
    chk("R2 no partial step", 32'(phase_out), 32'h0);

    // R6: strobe low at top address, and out-of-range addresses
    wr_byte(8'h06, 8'h7F, 0, "R6");
    wr_byte(8'h02, 8'hAA, 1, "R6");
    wr_byte(8'h07, 8'h55, 1, "R6");
    repeat (8) step_cycle("R6");
    chk("R6 ignored writes", 32'(phase_out), 32'h0);

    // R1/R2: commit; stage still holds FF FF FF, top byte 0x00 -> step 0x00FFFFFF
    wr_byte(8'h06, 8'h00, 1, "R1");
    chk("R2 commit edge", 32'(phase_out), 32'h0);
    step_cycle("R1");
    chk("R1 first step", 32'(phase_out), 32'h00F);

    // R5: step 2^28 gives one pulse per 16 cycles
    load_word(32'h1000_0000, "R5");
    pulses = 0;
    for (int i = 0; i < 64; i++) begin
      step_cycle("R5");
      if (wrap_pulse) pulses++;
    end
    chk("R5 pulse count", 32'(pulses), 32'd4);

    // R3/R4: sweep words and signed errors
    foreach (words[wi]) begin
      foreach (errs[ei]) begin
        freq_err = errs[ei];
        load_word(words[wi], "R4");
        for (int c = 0; c < 40; c++) step_cycle("R3");
      end
    end

    // R3: error changing every cycle is applied live
    load_word(32'h0200_0000, "R3");
    for (int i = 0; i < 300; i++) begin
      freq_err = 16'(i * 4099);
      step_cycle("R3 live");
    end

    // R3: negative error larger than the word wraps the step
    freq_err = 16'hFFFF;
    load_word(32'h0000_0000, "R3");
    for (int i = 0; i < 50; i++) step_cycle("R3 wrap");
    freq_err = 0;

    // R7: reset mid-run clears outputs
    @(negedge clk);
    model_run = 0;
    rst_n = 0;
    #1;
    chk("R7 async clear phase", 32'(phase_out), 32'h0);
    chk("R7 async clear wrap", 32'(wrap_pulse), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule